// File: doc/BRIEF.md
# Flash Read Wait-State Sequencer

This block times instruction fetches that a cache passes to a slow non-volatile memory array. The requester presents a read together with the hit/miss result of an external tag lookup. The block decides how many cycles the read takes and answers with a single-cycle valid pulse. When the read has to go to the array, it also pulses an array read strobe. Only one read is outstanding at a time: `req_ready` is low from the moment a read is accepted until its response has been given.

Timing comes from a 32-bit control word written through `cfg_we`/`cfg_wdata`, and two fields of that word matter. The first is a wait-state count from 0 to 15. The second is a timing policy, which is one of three:
- a miss costs only the programmed waits;
- a miss costs one extra cycle to save power;
- hits are padded so that every read takes the same time as a miss.

The fields in effect are captured when a read is accepted, so a rewrite never disturbs a read already in progress.

Top module: `fws_seq`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` and `arr_rd` are 0, the wait count is 0 and the policy is "no miss penalty", so a miss answers on the cycle after acceptance.
- R2: The wait count is `cfg_wdata[4:1]`, taken as a plain binary number. Under policy 0 a miss accepted at edge k raises `rsp_valid` in the cycle after edge k+W. All other control-word bits are ignored.
- R3: The policy is `cfg_wdata[17:16]`. Under policy 0 or 1, a hit answers in the cycle right after acceptance, whatever W is.
- R4: Under policy 1, a miss takes one cycle more than under policy 0, so `rsp_valid` is high in the cycle after edge k+W+1.
- R5: Under policy 2, hits and misses both answer in the cycle after edge k+W.
- R6: Policy value 3 behaves exactly as policy 0.
- R7: A control write while a read is in flight leaves that read's timing unchanged. The next accepted read uses the new values.
- R8: Each accepted read produces exactly one `rsp_valid` pulse, one cycle long. `req_ready` is low from acceptance until that pulse has ended, and `req_valid` is ignored while `req_ready` is low.
- R9: `arr_rd` pulses for one cycle, in the cycle after a miss is accepted, and it never rises for a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word (policy in 17:16, waits in 4:1) |
| req_valid | input | 1 | Read request |
| req_hit | input | 1 | Tag lookup result sampled with the request (1 = hit) |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| arr_rd | output | 1 | Array read strobe for misses |

## Verification
The assertions take for granted that `req_hit` is meaningful only in a cycle where `req_valid` and `req_ready` are both high. They also take for granted that the requester tolerates any wait between its request and the response. The bench drives `req_hit` only alongside an accepted request and lowers `req_valid` once the request is taken, except in the scenario that deliberately holds `req_valid` high while the block is busy. Control writes are placed both between reads and inside a read, so that both capture points are exercised.

// File: rtl/fws_pkg.sv
package fws_pkg;

    localparam int CTRL_W   = 32;
    localparam int WS_W     = 4;
    localparam int WS_LSB   = 1;
    localparam int MODE_W   = 2;
    localparam int MODE_LSB = 16;
    localparam int CNT_W    = WS_W + 1;

    typedef enum logic [MODE_W-1:0] {
        RM_NO_PENALTY = 2'd0,
        RM_LOW_POWER  = 2'd1,
        RM_FIXED      = 2'd2,
        RM_RSVD       = 2'd3
    } rd_mode_e;

    typedef struct packed {
        rd_mode_e         mode;
        logic [WS_W-1:0]  ws;
    } fws_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;

    // Extract the timing fields; the reserved policy folds onto policy 0.
    function automatic fws_cfg_t decode_ctl(input logic [CTRL_W-1:0] word);
        fws_cfg_t c;
        c.ws   = word[WS_LSB +: WS_W];
        c.mode = rd_mode_e'(word[MODE_LSB +: MODE_W]);
        if (c.mode == RM_RSVD) c.mode = RM_NO_PENALTY;
        return c;
    endfunction

    // Cycles to wait beyond the minimum single-cycle answer.
    function automatic logic [CNT_W-1:0] extra_waits(input fws_cfg_t c, input logic hit);
        logic [CNT_W-1:0] base;
        base = {1'b0, c.ws};
        unique case (c.mode)
            RM_LOW_POWER: extra_waits = hit ? '0 : base + CNT_W'(1);
            RM_FIXED:     extra_waits = base;
            default:      extra_waits = hit ? '0 : base;
        endcase
    endfunction

endpackage

// File: rtl/fws_cfg_reg.sv
module fws_cfg_reg
    import fws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output fws_cfg_t          cfg_o
);
    fws_cfg_t cfg_q;
    logic     unused_bits;

    assign unused_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= RM_NO_PENALTY;
            cfg_q.ws   <= '0;
        end else if (wr_en) begin
            cfg_q <= decode_ctl(wr_data);
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/fws_lat_calc.sv
module fws_lat_calc
    import fws_pkg::*;
(
    input  fws_cfg_t         cfg_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] extra_o
);
    always_comb begin
        extra_o = extra_waits(cfg_i, hit_i);
    end
endmodule

// File: rtl/fws_timer.sv
module fws_timer
    import fws_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_val,
    input  logic         is_miss,
    output logic         ready,
    output logic         done,
    output logic         strobe
);
    localparam logic [W-1:0] ONE = W'(1);

    seq_st_e      st_q;
    logic [W-1:0] cnt_q;
    logic         strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= start && is_miss;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    if (load_val == '0) begin
                        st_q <= ST_DONE;
                    end else begin
                        st_q  <= ST_WAIT;
                        cnt_q <= load_val - ONE;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) st_q <= ST_DONE;
                    else             cnt_q <= cnt_q - ONE;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ready  = (st_q == ST_IDLE);
    assign done   = (st_q == ST_DONE);
    assign strobe = strobe_q;
endmodule

// File: rtl/fws_seq.sv
module fws_seq
    import fws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_hit,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              arr_rd
);
    fws_cfg_t         cfg_q;
    rd_mode_e         act_mode;
    logic [CNT_W-1:0] extra;
    logic             accept;
    logic             rdy;

    fws_cfg_reg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg_q)
    );

    fws_lat_calc i_lat (
        .cfg_i   (cfg_q),
        .hit_i   (req_hit),
        .extra_o (extra)
    );

    assign accept   = req_valid && rdy;
    assign act_mode = cfg_q.mode;

    fws_timer #(.W(CNT_W)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .load_val (extra),
        .is_miss  (!req_hit),
        .ready    (rdy),
        .done     (rsp_valid),
        .strobe   (arr_rd)
    );

    assign req_ready = rdy;
endmodule

// File: rtl/fws_seq_chk.sv
module fws_seq_chk
    import fws_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     req_valid,
    input logic     req_hit,
    input logic     req_ready,
    input logic     rsp_valid,
    input logic     arr_rd,
    input rd_mode_e mode
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R8
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready); // R8
    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rsp_valid); // R8
    AST_STROBE_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_hit) |=> arr_rd); // R9
    AST_NO_STROBE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (acc && req_hit) |=> !arr_rd); // R9
    AST_HIT_FAST: assert property (@(posedge clk) disable iff (rst)
        (acc && req_hit && mode != RM_FIXED) |=> rsp_valid); // R3
    AST_RSVD_FOLDED: assert property (@(posedge clk) disable iff (rst)
        mode != RM_RSVD); // R6
endmodule

bind fws_seq fws_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_hit   (req_hit),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .arr_rd    (arr_rd),
    .mode      (act_mode)
);

// File: tb/test_fws_seq.sv
module test_fws_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_hit = 1'b0;
    logic        req_ready, rsp_valid, arr_rd;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fws_seq i_fws_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_hit(req_hit),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .arr_rd(arr_rd)
    );

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int mode, input int ws);
        // junk in unrelated bits must be ignored (R2)
        return 32'hA5C0_8081 | (32'(mode & 3) << 16) | (32'(ws & 15) << 1);
    endfunction

    task automatic write_cfg(input int mode, input int ws);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = ctl(mode, ws);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present a request and return just after the edge that accepts it.
    task automatic issue(input logic hit);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_hit = hit;
        @(posedge clk);
    endtask

    // Count negedges until rsp_valid; optional control write in the first cycle.
    task automatic collect(input logic hit, input int exp, input string tag,
                           input logic do_wr, input logic [31:0] wr_word);
        int n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0;
                if (do_wr) begin cfg_we = 1'b1; cfg_wdata = wr_word; end
                check(int'(arr_rd), int'(!hit), {tag, " R9 strobe"});
            end else begin
                cfg_we = 1'b0;
            end
            n++;
            if (rsp_valid) break;
        end
        cfg_we = 1'b0;
        check(n, exp, {tag, " latency"});
        @(negedge clk);
        check(int'(rsp_valid), 0, {tag, " R8 pulse width"});
        check(int'(req_ready), 1, {tag, " R8 ready back"});
    endtask

    task automatic do_req(input logic hit, input int exp, input string tag);
        issue(hit);
        collect(hit, exp, tag, 1'b0, '0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(int'(req_ready), 1, "R1 ready after reset");
        check(int'(rsp_valid), 0, "R1 rsp after reset");
        check(int'(arr_rd),    0, "R1 strobe after reset");
        do_req(1'b0, 1, "R1 default miss");
    endtask

    task automatic t_mode0();
        write_cfg(0, 5);
        do_req(1'b0, 6, "R2 ws5 miss");
        do_req(1'b1, 1, "R3 ws5 hit");
        write_cfg(0, 15);
        do_req(1'b0, 16, "R2 ws15 miss");
        do_req(1'b1, 1, "R3 ws15 hit");
        write_cfg(0, 0);
        do_req(1'b0, 1, "R2 ws0 miss");
    endtask

    task automatic t_low_power();
        write_cfg(1, 3);
        do_req(1'b0, 5, "R4 ws3 miss");
        do_req(1'b1, 1, "R4 ws3 hit");
        write_cfg(1, 0);
        do_req(1'b0, 2, "R4 ws0 miss");
        write_cfg(1, 15);
        do_req(1'b0, 17, "R4 ws15 miss");
    endtask

    task automatic t_fixed();
        write_cfg(2, 4);
        do_req(1'b1, 5, "R5 ws4 hit");
        do_req(1'b0, 5, "R5 ws4 miss");
        write_cfg(2, 0);
        do_req(1'b1, 1, "R5 ws0 hit");
    endtask

    task automatic t_reserved();
        write_cfg(3, 6);
        do_req(1'b0, 7, "R6 ws6 miss");
        do_req(1'b1, 1, "R6 ws6 hit");
    endtask

    task automatic t_midflight();
        write_cfg(0, 2);
        issue(1'b0);
        collect(1'b0, 3, "R7 in flight", 1'b1, ctl(1, 9));
        do_req(1'b0, 11, "R7 next uses new");
    endtask

    task automatic t_busy_ignored();
        int pulses = 0;
        write_cfg(0, 3);
        issue(1'b0);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (i == 1) check(int'(req_ready), 0, "R8 busy after accept");
            if (i == 3) req_valid = 1'b0;
            if (rsp_valid) begin
                pulses++;
                check(i, 4, "R8 busy latency");
            end
        end
        check(pulses, 1, "R8 one response while busy");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode0();
        t_low_power();
        t_fixed();
        t_reserved();
        t_midflight();
        t_busy_ignored();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule